// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the software-facing side of a byte-oriented UART. A processor reaches it through a 32-bit word register bus. Through that bus software writes bytes to send, reads the last byte received, and sets the baud divisor and the control and debug settings. Toward the serial engine it offers a byte handshake in each direction. It also exports the divisor and a break-enable level, which the baud generator and the line driver use. The serial engine itself is not part of this block.

Completion of a receive and completion of a transmit are each kept as a sticky event flag. Software clears a flag by writing a one to its status bit. The two flags are masked by per-event enable bits and merged into a single registered level interrupt. There is no FIFO. The receive side holds one byte and refuses the next until software has cleared the receive event.

Top module: `uart_regif`

## Requirements
- R1: After a synchronous reset, divisor, control, debug and the received byte are zero, both event flags are clear, status reads 0x1, `irq` and `tx_valid` are 0, and `rx_ready` is 1.
- R2: The byte address selects a register by word index: 0 data, 4 divisor, 8 status, 12 control, 16 debug. Address bits [1:0] are ignored.
- R3: Divisor, control and debug store and read back all 32 written bits. `div_out` equals the divisor. `brk_en` equals debug bit 0. Control bit 2 is stored only and drives nothing.
- R4: Status reads bit 0 = 1 always, bit 1 = receive event, bit 2 = transmit event, and all other bits 0.
- R5: A write to the data register puts write bits [7:0] on `tx_data` and raises `tx_valid` for exactly one cycle, starting at the clock edge that takes the write. It also sets the transmit event.
- R6: A status write clears the receive event where write bit 1 is 1 and the transmit event where write bit 2 is 1. Bit 0 and all other bits have no effect.
- R7: When `rx_valid` and `rx_ready` are both high at a clock edge, `rx_data` is latched and the receive event is set, which drops `rx_ready`. While the receive event is set, offered bytes are ignored.
- R8: A read of the data register returns the last received byte, zero-extended. A write to the data register does not change this value.
- R9: `irq` is a register that takes (control bit 0 AND receive event) OR (control bit 1 AND transmit event). It changes one cycle after the flags or enables change.
- R10: Writes to byte addresses 20 and above change no register, and reads there return zero.
- R11: A status write that clears the receive event and an accepted byte in the same cycle leave the receive event set, with the new byte latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| tx_data | output | BYTE_W | Byte handed to the transmitter |
| tx_valid | output | 1 | One-cycle pulse, byte on `tx_data` is new |
| rx_data | input | BYTE_W | Byte offered by the receiver |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_ready | output | 1 | Block can take a byte |
| div_out | output | DATA_W | Baud divisor value |
| brk_en | output | 1 | Break enable level |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit data word, 8-bit bytes and a 5-bit byte address. The 5-bit address gives three word slots past the debug register, so R10 writes and reads can reach unmapped addresses and show that they alias onto nothing. Full-width patterns in the divisor and debug registers show that all 32 bits are stored. Tests also show that only bit 0 of the debug register drives `brk_en`. Directed sequences cover the refused second byte, the one-cycle interrupt lag, masking by the enables, and the same-cycle clear and receive.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

    // register selector decoded from the word index
    typedef enum logic [2:0] {
        SEL_DATA,
        SEL_DIV,
        SEL_STAT,
        SEL_CTRL,
        SEL_DBG,
        SEL_NONE
    } reg_sel_e;

    // bit positions inside status, control and debug words
    localparam int STAT_THRE_BIT = 0;
    localparam int STAT_RX_BIT   = 1;
    localparam int STAT_TX_BIT   = 2;
    localparam int CTRL_RXIE_BIT = 0;
    localparam int CTRL_TXIE_BIT = 1;
    localparam int DBG_BRK_BIT   = 0;

    typedef struct packed {
        logic rx;
        logic tx;
    } evt_t;

    function automatic reg_sel_e decode_word(input logic [31:0] idx);
        reg_sel_e s;
        case (idx)
            32'd0:   s = SEL_DATA;
            32'd1:   s = SEL_DIV;
            32'd2:   s = SEL_STAT;
            32'd3:   s = SEL_CTRL;
            32'd4:   s = SEL_DBG;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/uart_regif_regs.sv
module uart_regif_regs
    import uart_regif_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  evt_t              evt,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              data_wr,
    output logic              stat_wr,
    output logic [DATA_W-1:0] div_q,
    output logic              rx_ie,
    output logic              tx_ie,
    output logic              brk
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  word_idx;
    reg_sel_e          sel;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] dbg_q;
    logic [DATA_W-1:0] stat_word;
    logic              unused_addr_lsbs;

    assign word_idx         = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsbs = ^bus_addr[1:0];
    assign sel              = decode_word(32'(word_idx));

    assign data_wr = bus_wr && (sel == SEL_DATA);
    assign stat_wr = bus_wr && (sel == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            ctrl_q <= '0;
            dbg_q  <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_DIV:  div_q  <= bus_wdata;
                SEL_CTRL: ctrl_q <= bus_wdata;
                SEL_DBG:  dbg_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        stat_word                = '0;
        stat_word[STAT_THRE_BIT] = 1'b1;
        stat_word[STAT_RX_BIT]   = evt.rx;
        stat_word[STAT_TX_BIT]   = evt.tx;
    end

    always_comb begin
        case (sel)
            SEL_DATA: bus_rdata = {{(DATA_W-BYTE_W){1'b0}}, rx_byte};
            SEL_DIV:  bus_rdata = div_q;
            SEL_STAT: bus_rdata = stat_word;
            SEL_CTRL: bus_rdata = ctrl_q;
            SEL_DBG:  bus_rdata = dbg_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign rx_ie = ctrl_q[CTRL_RXIE_BIT];
    assign tx_ie = ctrl_q[CTRL_TXIE_BIT];
    assign brk   = dbg_q[DBG_BRK_BIT];

    // R10: unmapped reads are zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (bus_rdata == '0));

    // R10: unmapped writes leave stored registers alone
    p_unmapped_write_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_NONE) |=> ($stable(div_q) && $stable(ctrl_q) && $stable(dbg_q)));

    // R4: THRE always reads one
    p_stat_thre_r4: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_STAT) |-> bus_rdata[STAT_THRE_BIT]);

endmodule

// File: rtl/uart_regif_events.sv
module uart_regif_events
    import uart_regif_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              data_wr,
    input  logic              stat_wr,
    input  logic              clr_rx_bit,
    input  logic              clr_tx_bit,
    input  logic [BYTE_W-1:0] tx_byte_in,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_ie,
    input  logic              tx_ie,
    output evt_t              evt_q,
    output logic [BYTE_W-1:0] rx_byte_q,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq
);
    logic accept;

    assign rx_ready = ~evt_q.rx;
    assign accept   = rx_valid && rx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q     <= '0;
            rx_byte_q <= '0;
            tx_valid  <= 1'b0;
            tx_data   <= '0;
            irq       <= 1'b0;
        end else begin
            // receive flag: a set beats a same-cycle clear
            if (accept) begin
                evt_q.rx  <= 1'b1;
                rx_byte_q <= rx_data;
            end else if (stat_wr && clr_rx_bit) begin
                evt_q.rx <= 1'b0;
            end
            // transmit flag
            if (data_wr) begin
                evt_q.tx <= 1'b1;
            end else if (stat_wr && clr_tx_bit) begin
                evt_q.tx <= 1'b0;
            end
            tx_valid <= data_wr;
            if (data_wr) begin
                tx_data <= tx_byte_in;
            end
            irq <= (rx_ie && evt_q.rx) || (tx_ie && evt_q.tx);
        end
    end

    // R5: a transmit pulse always coincides with a set transmit event
    p_tx_evt_r5: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> evt_q.tx);

    // R7: an accepted byte sets the receive event
    p_rx_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready) |=> evt_q.rx);

    // R7: held byte does not change while the event is pending
    p_rx_hold_r7: assert property (@(posedge clk) disable iff (rst)
        evt_q.rx |=> $stable(rx_byte_q));

    // R6: a clearing status write drops the transmit event
    p_tx_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && clr_tx_bit) |=> !evt_q.tx);

    // R9: interrupt only follows a pending event
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(evt_q.rx || evt_q.tx));

endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [DATA_W-1:0] div_out,
    output logic              brk_en,
    output logic              irq
);
    evt_t              evt;
    logic [BYTE_W-1:0] rx_byte;
    logic              data_wr;
    logic              stat_wr;
    logic              rx_ie;
    logic              tx_ie;

    uart_regif_regs #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt       (evt),
        .rx_byte   (rx_byte),
        .data_wr   (data_wr),
        .stat_wr   (stat_wr),
        .div_q     (div_out),
        .rx_ie     (rx_ie),
        .tx_ie     (tx_ie),
        .brk       (brk_en)
    );

    uart_regif_events #(
        .BYTE_W (BYTE_W)
    ) events_i (
        .clk        (clk),
        .rst        (rst),
        .data_wr    (data_wr),
        .stat_wr    (stat_wr),
        .clr_rx_bit (bus_wdata[STAT_RX_BIT]),
        .clr_tx_bit (bus_wdata[STAT_TX_BIT]),
        .tx_byte_in (bus_wdata[BYTE_W-1:0]),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ie      (rx_ie),
        .tx_ie      (tx_ie),
        .evt_q      (evt),
        .rx_byte_q  (rx_byte),
        .rx_ready   (rx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .irq        (irq)
    );

endmodule

// File: tb/uart_regif_tb_top.sv
module uart_regif_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [BYTE_W-1:0] tx_data;
    logic              tx_valid;
    logic [BYTE_W-1:0] rx_data = '0;
    logic              rx_valid = 1'b0;
    logic              rx_ready;
    logic [DATA_W-1:0] div_out;
    logic              brk_en;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regif #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .div_out(div_out), .brk_en(brk_en), .irq(irq)
    );

    typedef struct packed {
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdata;
        logic [ADDR_W-1:0] raddr;
        logic [DATA_W-1:0] exp;
    } vec_t;

    // R3 storage, R10 unmapped slots, R2 low address bits ignored
    localparam vec_t VECS [7] = '{
        '{5'd4,  32'hDEADBEEF, 5'd4,  32'hDEADBEEF},
        '{5'd12, 32'h00000004, 5'd12, 32'h00000004},
        '{5'd16, 32'hA5A5A5A4, 5'd16, 32'hA5A5A5A4},
        '{5'd20, 32'hFFFFFFFF, 5'd20, 32'h00000000},
        '{5'd28, 32'h12345678, 5'd4,  32'hDEADBEEF},
        '{5'd7,  32'h00000010, 5'd4,  32'h00000010},
        '{5'd24, 32'h00000001, 5'd24, 32'h00000000}
    };

    task automatic check(input string what, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", what, act, exp);
        end
    endtask

    // drive at a falling edge, return at the falling edge after the taking edge
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic offer_byte(input logic [BYTE_W-1:0] b);
        @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, all requirements R1 to R11 incomplete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        bus_read(5'd8, rd);  check("R1 status after reset", rd, 32'h1);
        bus_read(5'd0, rd);  check("R1 data after reset", rd, 32'h0);
        bus_read(5'd12, rd); check("R1 control after reset", rd, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
        check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
        check("R1 div_out", div_out, 32'h0);

        // table walk
        foreach (VECS[i]) begin
            bus_write(VECS[i].waddr, VECS[i].wdata);
            bus_read(VECS[i].raddr, rd);
            check($sformatf("R2/R3/R10 table entry %0d", i), rd, VECS[i].exp);
        end
        check("R3 div_out follows divisor", div_out, 32'h10);
        check("R3 brk_en low for even debug word", {31'b0, brk_en}, 32'h0);
        bus_write(5'd16, 32'h1);
        check("R3 brk_en from debug bit 0", {31'b0, brk_en}, 32'h1);
        check("R10 irq unaffected by ctrl bit2", {31'b0, irq}, 32'h0);

        // transmit path
        bus_write(5'd12, 32'h3);
        bus_write(5'd0, 32'h1C5);
        check("R5 tx_valid pulse", {31'b0, tx_valid}, 32'h1);
        check("R5 tx_data low byte", {24'b0, tx_data}, 32'hC5);
        check("R9 irq lags one cycle", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R5 tx_valid single cycle", {31'b0, tx_valid}, 32'h0);
        check("R9 irq from tx event", {31'b0, irq}, 32'h1);
        bus_read(5'd8, rd); check("R4 status tx event", rd, 32'h5);
        bus_read(5'd0, rd); check("R8 data write keeps rx byte", rd, 32'h0);
        bus_write(5'd8, 32'h4);
        bus_read(5'd8, rd); check("R6 clear tx event", rd, 32'h1);
        @(negedge clk);
        check("R9 irq drops after clear", {31'b0, irq}, 32'h0);

        // receive path
        offer_byte(8'h3A);
        check("R7 rx_ready drops", {31'b0, rx_ready}, 32'h0);
        bus_read(5'd8, rd); check("R4 status rx event", rd, 32'h3);
        bus_read(5'd0, rd); check("R8 data read rx byte", rd, 32'h3A);
        offer_byte(8'h77);
        bus_read(5'd0, rd); check("R7 second byte ignored", rd, 32'h3A);
        check("R9 irq from rx event", {31'b0, irq}, 32'h1);
        bus_write(5'd12, 32'h2);
        @(negedge clk);
        check("R9 rx interrupt masked", {31'b0, irq}, 32'h0);
        bus_write(5'd8, 32'hFFFFFFF9);
        bus_read(5'd8, rd); check("R6 bits other than 1 and 2 ignored", rd, 32'h3);
        bus_write(5'd8, 32'h2);
        bus_read(5'd8, rd); check("R6 clear rx event", rd, 32'h1);
        check("R7 rx_ready back", {31'b0, rx_ready}, 32'h1);

        // R11 same-cycle clear and receive
        @(negedge clk);
        bus_addr  = 5'd8;
        bus_wdata = 32'h2;
        bus_wr    = 1'b1;
        rx_data   = 8'h55;
        rx_valid  = 1'b1;
        @(negedge clk);
        bus_wr   = 1'b0;
        rx_valid = 1'b0;
        bus_read(5'd8, rd); check("R11 set wins over clear", rd, 32'h3);
        bus_read(5'd0, rd); check("R11 new byte latched", rd, 32'h55);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule